// File: doc/BRIEF.md
# Store Queue with Deferred, Tagged Writeback

This block keeps stores in program order from the moment they are allocated until memory has acknowledged them. It is a circular buffer of `DEPTH + 1` slots. One slot is always left unused, so that a full ring and an empty ring can be told apart from the pointer values alone. Three pointers move around the ring:

- the retire head;
- the writeback index, which marks the next store to offer to memory;
- the allocation tail.

A commit input names the youngest committed sequence number. It turns the matching stores into writeback candidates. An engine then offers those candidates to memory strictly in order. It uses up to `PORTS` request lanes per cycle, and each request carries the slot index as its tag.

Memory may accept or refuse each request in the same cycle. A refusal stops the engine until a retry pulse arrives. Completions come back by tag in any order. The head only moves across a contiguous run of completed entries, so retirement stays in order even when acknowledgements do not.

Some entries never need a memory write:

- A store whose size is zero completes inside the block, and uses no lane.
- A prefetch-type store takes a lane slot, sends nothing, and completes.

A store-conditional becomes a candidate as soon as it executes without a fault, with no commit needed.

Squash trims stores from the tail backward. It stops at the first store that is already a candidate.

In a squash cycle, allocation, execute and commit inputs are ignored.

A store is expected to be executed before it is committed. An entry that has not been executed reads as size zero.

Top module: `store_queue`

## Requirements
- R1: After reset, q_count is 0, q_full is 0, alloc_idx is 0 and no mem_wr_valid bit is set.
- R2: The queue holds at most DEPTH stores. alloc_idx gives the slot the next allocation takes, and this index wraps modulo DEPTH+1. While q_full is 1, an allocation request changes neither alloc_idx nor q_count.
- R3: Commit walks from the head toward the tail. It marks every store that is not yet a candidate and whose sequence number is at most the commit number. It stops at the first store that is not a candidate and is younger than the commit number; that store and everything behind it stay unwritten.
- R4: A store-conditional executed with exec_fault 0 becomes a candidate without a commit. Its request appears in the cycle after the execute. With exec_fault 1, no request is made.
- R5: Candidates are offered in ring order, at most PORTS per cycle. Offers fill lanes from lane 0 upward; lane l carries its tag in mem_wr_tag bits [l*IDX_W +: IDX_W]. The first offer appears in the cycle after the store became a candidate. Offers that do not fit continue in the next cycle.
- R6: A candidate of size zero completes without any memory request and without using a lane. It retires in the cycle after it is reached.
- R7: A completion (cmpl_valid with cmpl_idx equal to a tag) marks that store done. q_count drops only when the head store is done, and then by the length of the run of done stores starting at the head. A completion for a store behind a not-done head leaves q_count unchanged.
- R8: A refused offer (mem_wr_valid[l] set with mem_wr_accept[l] clear) blocks the engine: no request is made until a mem_retry pulse. In the cycle after the retry, the same store is offered again with the same tag.
- R9: A prefetch-type candidate uses up one lane for that cycle but sends no request. It retires as completed. A following ordinary store goes out on the next lane.
- R10: Squash removes stores from the tail backward while they are not candidates and have a sequence number greater than the squash number. It stops at the first candidate, never removing it. The tail, and so alloc_idx, moves back to the first removed slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated store |
| alloc_prefetch | input | 1 | Allocated store is a prefetch type |
| alloc_idx | output | IDX_W | Slot the next allocation takes (tail) |
| q_full | output | 1 | DEPTH stores held |
| q_count | output | CNT_W | Number of stores held |
| exec_valid | input | 1 | Execute result for one slot |
| exec_idx | input | IDX_W | Slot being executed |
| exec_size | input | SIZE_W | Access size; zero means no data |
| exec_cond | input | 1 | Store is a store-conditional |
| exec_fault | input | 1 | Execution faulted |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Stores younger than this are removed |
| mem_wr_valid | output | PORTS | Write request per lane |
| mem_wr_tag | output | PORTS*IDX_W | Slot index per lane |
| mem_wr_size | output | PORTS*SIZE_W | Access size per lane |
| mem_wr_accept | input | PORTS | Memory takes the request on that lane this cycle |
| mem_retry | input | 1 | Memory can take refused traffic again |
| cmpl_valid | input | 1 | Write acknowledgement |
| cmpl_idx | input | IDX_W | Tag being acknowledged |

## Verification
A single committed store checks the basic path from candidate to request to retire. A commit that covers only part of the queue separates the stopping rule from a commit-everything walk. Three stores committed at once against two lanes show whether the port budget is honoured and whether the leftover store carries over.

A queue that mixes zero-size, prefetch and ordinary entries shows which entries use a lane and which reach memory. Acknowledging stores in reverse order separates in-order retirement from retirement as each acknowledgement arrives. A squash that reaches a written store shows whether committed entries are protected.

A refused request followed by a retry checks the blocking and the re-offer. Twelve allocate-write-complete rounds carry the tags past the ring boundary to check the index wrap.

// File: rtl/sq_pkg.sv
package sq_pkg;

   // Move a ring index by delta (which may be negative), wrapping modulo slots.
   function automatic int ring_step(int idx, int delta, int slots);
      return (((idx + delta) % slots) + slots) % slots;
   endfunction

endpackage

// File: rtl/sq_commit_scan.sv
module sq_commit_scan #(
   parameter int SLOTS = 5,
   parameter int IDX_W = 3,
   parameter int SEQ_W = 16
) (
   input  logic             en,
   input  logic [SEQ_W-1:0] youngest,
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] tail,
   input  logic [SLOTS-1:0] elig,
   input  logic [SEQ_W-1:0] seq [SLOTS],
   output logic [SLOTS-1:0] mark
);

   logic             go;
   logic [IDX_W-1:0] pos;

   always_comb begin
      mark = '0;
      go   = en;
      pos  = head;
      for (int s = 0; s < SLOTS - 1; s++) begin
         if (go && pos != tail) begin
            if (!elig[pos]) begin
               if (seq[pos] > youngest) go = 1'b0;
               else mark[pos] = 1'b1;
            end
            if (go) pos = IDX_W'(sq_pkg::ring_step(int'(pos), 1, SLOTS));
         end else begin
            go = 1'b0;
         end
      end
   end

endmodule

// File: rtl/sq_squash_scan.sv
module sq_squash_scan #(
   parameter int SLOTS = 5,
   parameter int IDX_W = 3,
   parameter int SEQ_W = 16
) (
   input  logic             en,
   input  logic [SEQ_W-1:0] limit,
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] tail,
   input  logic [SLOTS-1:0] elig,
   input  logic [SEQ_W-1:0] seq [SLOTS],
   output logic [SLOTS-1:0] kill,
   output logic [IDX_W-1:0] new_tail
);

   logic             go;
   logic [IDX_W-1:0] pos;
   logic [IDX_W-1:0] prv;

   always_comb begin
      kill     = '0;
      go       = en;
      pos      = tail;
      prv      = tail;
      new_tail = tail;
      for (int s = 0; s < SLOTS - 1; s++) begin
         if (go && pos != head) begin
            prv = IDX_W'(sq_pkg::ring_step(int'(pos), -1, SLOTS));
            if (!elig[prv] && seq[prv] > limit) begin
               kill[prv] = 1'b1;
               new_tail  = prv;
               pos       = prv;
            end else begin
               go = 1'b0;
            end
         end else begin
            go = 1'b0;
         end
      end
   end

endmodule

// File: rtl/sq_wb_engine.sv
module sq_wb_engine #(
   parameter int SLOTS  = 5,
   parameter int IDX_W  = 3,
   parameter int SIZE_W = 4,
   parameter int PORTS  = 2,
   parameter int CNT_W  = 3
) (
   input  logic [IDX_W-1:0]  wb_idx,
   input  logic [IDX_W-1:0]  tail,
   input  logic [CNT_W-1:0]  pending,
   input  logic              blocked,
   input  logic [SLOTS-1:0]  ready,
   input  logic [SLOTS-1:0]  zero,
   input  logic [SLOTS-1:0]  pf,
   input  logic [SIZE_W-1:0] size [SLOTS],
   input  logic [PORTS-1:0]  accept,
   output logic [PORTS-1:0]  wr_valid,
   output logic [IDX_W-1:0]  wr_tag [PORTS],
   output logic [SIZE_W-1:0] wr_size [PORTS],
   output logic [SLOTS-1:0]  fin,
   output logic [IDX_W-1:0]  wb_next,
   output logic              set_blocked
);

   logic             go;
   logic             ok;
   int               used;
   logic [IDX_W-1:0] pos;
   logic [CNT_W-1:0] left;

   // Walk from the writeback index: zero-size entries finish for free,
   // prefetch entries spend a lane, ordinary entries fill lanes in order.
   always_comb begin
      wr_valid    = '0;
      fin         = '0;
      set_blocked = 1'b0;
      go          = !blocked;
      ok          = 1'b0;
      used        = 0;
      pos         = wb_idx;
      left        = pending;
      for (int l = 0; l < PORTS; l++) begin
         wr_tag[l]  = '0;
         wr_size[l] = '0;
      end
      for (int s = 0; s < SLOTS - 1; s++) begin
         if (go && left != '0 && pos != tail && ready[pos]) begin
            if (zero[pos]) begin
               fin[pos] = 1'b1;
               left     = left - 1'b1;
               pos      = IDX_W'(sq_pkg::ring_step(int'(pos), 1, SLOTS));
            end else if (used >= PORTS) begin
               go = 1'b0;
            end else if (pf[pos]) begin
               fin[pos] = 1'b1;
               left     = left - 1'b1;
               used     = used + 1;
               pos      = IDX_W'(sq_pkg::ring_step(int'(pos), 1, SLOTS));
            end else begin
               ok = 1'b0;
               for (int l = 0; l < PORTS; l++) begin
                  if (l == used) begin
                     wr_valid[l] = 1'b1;
                     wr_tag[l]   = pos;
                     wr_size[l]  = size[pos];
                     ok          = accept[l];
                  end
               end
               if (ok) begin
                  used = used + 1;
                  pos  = IDX_W'(sq_pkg::ring_step(int'(pos), 1, SLOTS));
               end else begin
                  set_blocked = 1'b1;
                  go          = 1'b0;
               end
            end
         end else begin
            go = 1'b0;
         end
      end
      wb_next = pos;
   end

endmodule

// File: rtl/sq_retire.sv
module sq_retire #(
   parameter int SLOTS = 5,
   parameter int IDX_W = 3
) (
   input  logic [IDX_W-1:0] head,
   input  logic [IDX_W-1:0] tail,
   input  logic [SLOTS-1:0] done_next,
   output logic [SLOTS-1:0] retire,
   output logic [IDX_W-1:0] head_next
);

   logic go;

   always_comb begin
      retire    = '0;
      head_next = head;
      go        = 1'b1;
      for (int s = 0; s < SLOTS - 1; s++) begin
         if (go && head_next != tail && done_next[head_next]) begin
            retire[head_next] = 1'b1;
            head_next = IDX_W'(sq_pkg::ring_step(int'(head_next), 1, SLOTS));
         end else begin
            go = 1'b0;
         end
      end
   end

endmodule

// File: rtl/store_queue.sv
module store_queue #(
   parameter  int DEPTH  = 4,
   parameter  int PORTS  = 2,
   parameter  int SEQ_W  = 16,
   parameter  int SIZE_W = 4,
   localparam int SLOTS  = DEPTH + 1,
   localparam int IDX_W  = $clog2(SLOTS),
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    alloc_valid,
   input  logic [SEQ_W-1:0]        alloc_seq,
   input  logic                    alloc_prefetch,
   output logic [IDX_W-1:0]        alloc_idx,
   output logic                    q_full,
   output logic [CNT_W-1:0]        q_count,
   input  logic                    exec_valid,
   input  logic [IDX_W-1:0]        exec_idx,
   input  logic [SIZE_W-1:0]       exec_size,
   input  logic                    exec_cond,
   input  logic                    exec_fault,
   input  logic                    commit_valid,
   input  logic [SEQ_W-1:0]        commit_seq,
   input  logic                    squash_valid,
   input  logic [SEQ_W-1:0]        squash_seq,
   output logic [PORTS-1:0]        mem_wr_valid,
   output logic [PORTS*IDX_W-1:0]  mem_wr_tag,
   output logic [PORTS*SIZE_W-1:0] mem_wr_size,
   input  logic [PORTS-1:0]        mem_wr_accept,
   input  logic                    mem_retry,
   input  logic                    cmpl_valid,
   input  logic [IDX_W-1:0]        cmpl_idx
);

   if (DEPTH < 2 || PORTS < 1 || SEQ_W < 1 || SIZE_W < 1) begin : g_param_err
      $error("store_queue: DEPTH >= 2, PORTS >= 1 and nonzero widths required");
   end

   logic [IDX_W-1:0]  head_q, wb_q, tail_q;
   logic [CNT_W-1:0]  pend_q;
   logic              blk_q;
   logic [SLOTS-1:0]  valid_q, elig_q, done_q, pf_q;
   logic [SEQ_W-1:0]  seq_q  [SLOTS];
   logic [SIZE_W-1:0] size_q [SLOTS];

   logic              alloc_ok, exec_ok;
   logic [SLOTS-1:0]  mark, kill, sc_vec, newly, zero_v, ready_v;
   logic [SLOTS-1:0]  fin, ext_vec, ext_new, done_next, retire;
   logic [IDX_W-1:0]  sq_tail, wb_next, head_next;
   logic              set_blk;
   logic [IDX_W-1:0]  lane_tag  [PORTS];
   logic [SIZE_W-1:0] lane_size [PORTS];
   logic [CNT_W-1:0]  pend_n;

   assign q_count   = CNT_W'(sq_pkg::ring_step(int'(tail_q), -int'(head_q), SLOTS));
   assign q_full    = (int'(q_count) == DEPTH);
   assign alloc_idx = tail_q;
   assign alloc_ok  = alloc_valid && !squash_valid && !q_full;
   assign exec_ok   = exec_valid && !squash_valid;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      assign zero_v[i]  = (size_q[i] == '0);
      assign ready_v[i] = valid_q[i] && elig_q[i] && !done_q[i];
      assign sc_vec[i]  = exec_ok && exec_cond && !exec_fault && valid_q[i] &&
                          (exec_idx == IDX_W'(i));
      assign ext_vec[i] = cmpl_valid && (cmpl_idx == IDX_W'(i));
   end

   assign newly     = (mark | sc_vec) & ~elig_q;
   assign ext_new   = ext_vec & valid_q & ~done_q;
   assign done_next = done_q | fin | ext_new;
   assign pend_n    = CNT_W'(int'(pend_q) + $countones(newly)
                             - $countones(fin) - $countones(ext_new));

   sq_commit_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_commit (
      .en(commit_valid && !squash_valid), .youngest(commit_seq),
      .head(head_q), .tail(tail_q), .elig(elig_q), .seq(seq_q), .mark(mark));

   sq_squash_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_squash (
      .en(squash_valid), .limit(squash_seq), .head(head_q), .tail(tail_q),
      .elig(elig_q), .seq(seq_q), .kill(kill), .new_tail(sq_tail));

   sq_wb_engine #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SIZE_W(SIZE_W), .PORTS(PORTS),
                  .CNT_W(CNT_W)) u_wb (
      .wb_idx(wb_q), .tail(tail_q), .pending(pend_q), .blocked(blk_q),
      .ready(ready_v), .zero(zero_v), .pf(pf_q), .size(size_q),
      .accept(mem_wr_accept), .wr_valid(mem_wr_valid), .wr_tag(lane_tag),
      .wr_size(lane_size), .fin(fin), .wb_next(wb_next), .set_blocked(set_blk));

   sq_retire #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_retire (
      .head(head_q), .tail(tail_q), .done_next(done_next),
      .retire(retire), .head_next(head_next));

   for (genvar l = 0; l < PORTS; l++) begin : g_lane
      assign mem_wr_tag[l*IDX_W +: IDX_W]    = lane_tag[l];
      assign mem_wr_size[l*SIZE_W +: SIZE_W] = lane_size[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q  <= '0;
         wb_q    <= '0;
         tail_q  <= '0;
         pend_q  <= '0;
         blk_q   <= 1'b0;
         valid_q <= '0;
         elig_q  <= '0;
         done_q  <= '0;
         pf_q    <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            seq_q[i]  <= '0;
            size_q[i] <= '0;
         end
      end else begin
         head_q <= head_next;
         wb_q   <= wb_next;
         pend_q <= pend_n;
         if (set_blk)        blk_q <= 1'b1;
         else if (mem_retry) blk_q <= 1'b0;
         if (squash_valid)  tail_q <= sq_tail;
         else if (alloc_ok) tail_q <= IDX_W'(sq_pkg::ring_step(int'(tail_q), 1, SLOTS));
         for (int i = 0; i < SLOTS; i++) begin
            if (retire[i] || kill[i]) begin
               valid_q[i] <= 1'b0;
               elig_q[i]  <= 1'b0;
               done_q[i]  <= 1'b0;
               pf_q[i]    <= 1'b0;
               size_q[i]  <= '0;
            end else if (alloc_ok && tail_q == IDX_W'(i)) begin
               valid_q[i] <= 1'b1;
               elig_q[i]  <= 1'b0;
               done_q[i]  <= 1'b0;
               pf_q[i]    <= alloc_prefetch;
               seq_q[i]   <= alloc_seq;
               size_q[i]  <= '0;
            end else begin
               if (newly[i])     elig_q[i] <= 1'b1;
               if (done_next[i]) done_q[i] <= 1'b1;
               if (exec_ok && exec_idx == IDX_W'(i)) size_q[i] <= exec_size;
            end
         end
      end
   end

endmodule

// File: rtl/store_queue_chk.sv
module store_queue_chk #(
   parameter int DEPTH = 4,
   parameter int PORTS = 2,
   parameter int IDX_W = 3,
   parameter int CNT_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid,
   input logic             squash_valid,
   input logic             q_full,
   input logic [CNT_W-1:0] q_count,
   input logic [IDX_W-1:0] alloc_idx,
   input logic [PORTS-1:0] mem_wr_valid,
   input logic [PORTS-1:0] mem_wr_accept,
   input logic             blocked
);

   p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= DEPTH);

   p_full_holds_tail_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (q_full && alloc_valid && !squash_valid) |=> $stable(alloc_idx));

   p_no_growth_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !alloc_valid |=> q_count <= $past(q_count));

   p_blocked_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
      blocked |-> mem_wr_valid == '0);

   p_refuse_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr_valid[0] && !mem_wr_accept[0]) |=> mem_wr_valid == '0);

   p_squash_shrinks_r10: assert property (@(posedge clk) disable iff (!rst_n)
      squash_valid |=> q_count <= $past(q_count));

endmodule

bind store_queue store_queue_chk #(
   .DEPTH(DEPTH), .PORTS(PORTS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
   .squash_valid(squash_valid), .q_full(q_full), .q_count(q_count),
   .alloc_idx(alloc_idx), .mem_wr_valid(mem_wr_valid),
   .mem_wr_accept(mem_wr_accept), .blocked(blk_q)
);

// File: tb/store_queue_tb_top.sv
module store_queue_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH  = 4;
   localparam int PORTS  = 2;
   localparam int SEQ_W  = 16;
   localparam int SIZE_W = 4;
   localparam int SLOTS  = DEPTH + 1;
   localparam int IDX_W  = $clog2(SLOTS);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n;
   logic alloc_valid, alloc_prefetch;
   logic [SEQ_W-1:0] alloc_seq;
   logic [IDX_W-1:0] alloc_idx;
   logic q_full;
   logic [CNT_W-1:0] q_count;
   logic exec_valid, exec_cond, exec_fault;
   logic [IDX_W-1:0] exec_idx;
   logic [SIZE_W-1:0] exec_size;
   logic commit_valid, squash_valid;
   logic [SEQ_W-1:0] commit_seq, squash_seq;
   logic [PORTS-1:0] mem_wr_valid, mem_wr_accept;
   logic [PORTS*IDX_W-1:0] mem_wr_tag;
   logic [PORTS*SIZE_W-1:0] mem_wr_size;
   logic mem_retry, cmpl_valid;
   logic [IDX_W-1:0] cmpl_idx;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   store_queue #(.DEPTH(DEPTH), .PORTS(PORTS), .SEQ_W(SEQ_W), .SIZE_W(SIZE_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
      .alloc_prefetch(alloc_prefetch), .alloc_idx(alloc_idx), .q_full(q_full),
      .q_count(q_count), .exec_valid(exec_valid), .exec_idx(exec_idx),
      .exec_size(exec_size), .exec_cond(exec_cond), .exec_fault(exec_fault),
      .commit_valid(commit_valid), .commit_seq(commit_seq),
      .squash_valid(squash_valid), .squash_seq(squash_seq),
      .mem_wr_valid(mem_wr_valid), .mem_wr_tag(mem_wr_tag),
      .mem_wr_size(mem_wr_size), .mem_wr_accept(mem_wr_accept),
      .mem_retry(mem_retry), .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int tag_of(int l);
      return int'(mem_wr_tag[l*IDX_W +: IDX_W]);
   endfunction

   // One clock: inputs driven before are captured; pulses are then dropped.
   task automatic cyc();
      @(posedge clk);
      #1;
      alloc_valid = 0; exec_valid = 0; commit_valid = 0;
      squash_valid = 0; mem_retry = 0; cmpl_valid = 0;
      #1;
   endtask

   task automatic do_reset();
      rst_n = 0;
      alloc_valid = 0; alloc_seq = '0; alloc_prefetch = 0;
      exec_valid = 0; exec_idx = '0; exec_size = '0; exec_cond = 0; exec_fault = 0;
      commit_valid = 0; commit_seq = '0; squash_valid = 0; squash_seq = '0;
      mem_wr_accept = '1; mem_retry = 0; cmpl_valid = 0; cmpl_idx = '0;
      cyc(); cyc();
      rst_n = 1;
      cyc();
   endtask

   task automatic alloc(int seq, bit pf);
      alloc_valid = 1; alloc_seq = SEQ_W'(seq); alloc_prefetch = pf;
      cyc();
   endtask

   task automatic exec(int idx, int size, bit cond, bit fault);
      exec_valid = 1; exec_idx = IDX_W'(idx); exec_size = SIZE_W'(size);
      exec_cond = cond; exec_fault = fault;
      cyc();
      exec_cond = 0; exec_fault = 0;
   endtask

   task automatic commit(int seq);
      commit_valid = 1; commit_seq = SEQ_W'(seq);
      cyc();
   endtask

   task automatic squash(int seq);
      squash_valid = 1; squash_seq = SEQ_W'(seq);
      cyc();
   endtask

   task automatic complete(int idx);
      cmpl_valid = 1; cmpl_idx = IDX_W'(idx);
      cyc();
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 count", int'(q_count), 0);
      chk("R1 full", int'(q_full), 0);
      chk("R1 alloc_idx", int'(alloc_idx), 0);
      chk("R1 wr_valid", int'(mem_wr_valid), 0);
   endtask

   task automatic t_fill();
      do_reset();
      for (int i = 0; i < DEPTH; i++) begin
         chk("R2 alloc slot", int'(alloc_idx), i);
         alloc(i + 1, 0);
      end
      chk("R2 full", int'(q_full), 1);
      chk("R2 count", int'(q_count), DEPTH);
      alloc(9, 0);
      chk("R2 alloc ignored idx", int'(alloc_idx), DEPTH);
      chk("R2 alloc ignored count", int'(q_count), DEPTH);
   endtask

   task automatic t_commit();
      do_reset();
      alloc(10, 0); alloc(11, 0); alloc(12, 0);
      for (int i = 0; i < 3; i++) exec(i, 4, 0, 0);
      commit(11);
      chk("R3 two lanes", int'(mem_wr_valid), 3);
      chk("R5 lane0 tag", tag_of(0), 0);
      chk("R5 lane1 tag", tag_of(1), 1);
      chk("R5 lane0 size", int'(mem_wr_size[SIZE_W-1:0]), 4);
      cyc();
      chk("R3 younger unwritten", int'(mem_wr_valid), 0);
      complete(1);
      chk("R7 out of order no retire", int'(q_count), 3);
      complete(0);
      chk("R7 run retires", int'(q_count), 1);
      commit(12);
      chk("R3 later commit", int'(mem_wr_valid), 1);
      chk("R3 later tag", tag_of(0), 2);
      cyc();
      complete(2);
      chk("R7 empty", int'(q_count), 0);
   endtask

   task automatic t_budget();
      do_reset();
      alloc(1, 0); alloc(2, 0); alloc(3, 0);
      for (int i = 0; i < 3; i++) exec(i, 2, 0, 0);
      commit(100);
      chk("R5 budget first", int'(mem_wr_valid), 3);
      cyc();
      chk("R5 budget carry", int'(mem_wr_valid), 1);
      chk("R5 carry tag", tag_of(0), 2);
   endtask

   task automatic t_refuse();
      do_reset();
      alloc(5, 0);
      exec(0, 8, 0, 0);
      mem_wr_accept = '0;
      commit(5);
      chk("R8 offered", int'(mem_wr_valid), 1);
      cyc();
      chk("R8 blocked", int'(mem_wr_valid), 0);
      mem_wr_accept = '1;
      cyc();
      chk("R8 still blocked", int'(mem_wr_valid), 0);
      mem_retry = 1;
      cyc();
      chk("R8 reoffer", int'(mem_wr_valid), 1);
      chk("R8 reoffer tag", tag_of(0), 0);
   endtask

   task automatic t_zero();
      do_reset();
      alloc(1, 0); alloc(2, 0); alloc(3, 0);
      exec(0, 0, 0, 0); exec(1, 3, 0, 0); exec(2, 3, 0, 0);
      commit(3);
      chk("R6 no lane used", int'(mem_wr_valid), 3);
      chk("R6 lane0 tag", tag_of(0), 1);
      chk("R6 lane1 tag", tag_of(1), 2);
      cyc();
      chk("R6 retired", int'(q_count), 2);
   endtask

   task automatic t_prefetch();
      do_reset();
      alloc(1, 1); alloc(2, 0); alloc(3, 0);
      for (int i = 0; i < 3; i++) exec(i, 4, 0, 0);
      commit(3);
      chk("R9 lane1 only", int'(mem_wr_valid), 2);
      chk("R9 lane1 tag", tag_of(1), 1);
      cyc();
      chk("R9 retired", int'(q_count), 2);
      chk("R9 next cycle", int'(mem_wr_valid), 1);
      chk("R9 next tag", tag_of(0), 2);
   endtask

   task automatic t_squash();
      do_reset();
      alloc(20, 0); alloc(21, 0); alloc(22, 0);
      for (int i = 0; i < 3; i++) exec(i, 4, 0, 0);
      commit(20);
      cyc();
      squash(19);
      chk("R10 stops at committed", int'(q_count), 1);
      chk("R10 tail back", int'(alloc_idx), 1);
      alloc(23, 0);
      squash(22);
      chk("R10 younger removed", int'(q_count), 1);
      chk("R10 tail again", int'(alloc_idx), 1);
   endtask

   task automatic t_cond();
      do_reset();
      alloc(30, 0); alloc(31, 0);
      exec(1, 4, 1, 1);
      chk("R4 fault no write", int'(mem_wr_valid), 0);
      exec(0, 4, 1, 0);
      chk("R4 cond write", int'(mem_wr_valid), 1);
      chk("R4 cond tag", tag_of(0), 0);
   endtask

   task automatic t_wrap();
      do_reset();
      for (int i = 0; i < 12; i++) begin
         int slot;
         slot = int'(alloc_idx);
         chk("R2 wrap idx", slot, i % SLOTS);
         alloc(40 + i, 0);
         exec(slot, 1, 0, 0);
         commit(40 + i);
         chk("R5 wrap tag", tag_of(0), slot);
         cyc();
         complete(slot);
         chk("R7 wrap drained", int'(q_count), 0);
      end
   endtask

   initial begin
      t_reset();
      t_fill();
      t_commit();
      t_budget();
      t_refuse();
      t_zero();
      t_prefetch();
      t_squash();
      t_cond();
      t_wrap();
      if (!done_flag) begin
         done_flag = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done_flag) begin
         done_flag = 1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule